// File: doc/BRIEF.md
# Data Access Address Translator

This block turns the virtual address of a data load or store into a physical address and decides whether the access may go ahead. It takes the request (address, access size, direction and three request flags), the low bit of the program counter, two mode registers and the result of a translation-buffer lookup. The translation-buffer storage sits outside the block, and so does the logic that records faults. The block returns a physical address, an uncacheable marker and one fault code.

The checks form a fixed priority chain, and the first one that fails decides the fault code. Alignment is checked first. A request flagged physical skips translation. A non-physical address is then checked for a legal sign-extended form, tested for the kernel-only direct-mapped superpage window, and finally resolved through the lookup result together with its per-mode read and write permissions and fault-on bits. Every address that was formed is checked against the implemented physical width and then classified as cacheable or uncacheable.

The result is registered and appears one clock after the request. When any fault is reported, the address and uncacheable outputs read zero.

Top module: `xlat_data_unit`

## Requirements
- R1: If any address bit below the access size is set (size code 0..3 selects 1, 2, 4 or 8 bytes), the fault is ALIGN (code 1). This takes priority over every other check, including a physical request.
- R2: The effective mode is taken from the current-mode input when the PC low bit is 0. When the PC low bit is 1, the effective mode is the alternate-mode input if the alternate flag is set, and kernel (0) otherwise. Mode codes are kernel 0, executive 1, supervisor 2 and user 3, and each code indexes its bit in the permission masks.
- R3: A request flagged physical uses VA as the raw physical address and ignores the translation inputs.
- R4: For a non-physical request, VA bits 63:47 must all be equal. Otherwise the fault is BAD_VA (code 2).
- R5: A valid VA whose bits 47:41 equal 7'h7e is a superpage access. It raises ACV (code 3) unless the effective mode is kernel.
- R6: The superpage raw physical address is VA bits 43:0, with bits 43:40 forced to 4'hf when VA bit 40 is 1 and cleared to 0 when VA bit 40 is 0.
- R7: A remaining request with no lookup hit raises MISS_PTE (code 5) when the page-table-fetch flag is set, and MISS (code 4) otherwise.
- R8: On a hit, the raw physical address is (PPN << 13) + VA[12:0].
- R9: On a hit, a write whose effective-mode bit is clear in the write mask raises ACV. A read whose effective-mode bit is clear in the read mask also raises ACV.
- R10: On a hit with permission granted, a write to a page with its fault-on-write bit set raises FOW (code 7), and a read from a page with its fault-on-read bit set raises FOR (code 6).
- R11: A formed raw address with any bit at or above bit 44 set raises MCHK (code 8).
- R12: When raw bit 43 is 1 and raw bits 43:32 are not all ones (register space), the uncacheable output is 1 and output bits 42:35 are cleared. Otherwise the address is passed through unchanged with uncacheable 0.
- R13: The outputs are registered with one cycle of latency and read zero (fault NONE = 0) in reset. Whenever the fault is not NONE, the address and uncacheable outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_va | input | 64 | Virtual address of the access |
| req_size_log2 | input | 2 | log2 of the access size in bytes |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_phys | input | 1 | Treat the address as physical |
| req_alt | input | 1 | Use the alternate mode when the PC low bit is 1 |
| req_pte | input | 1 | Request is a page-table-entry fetch |
| pc_lsb | input | 1 | Bit 0 of the current PC |
| cur_mode | input | 2 | Current-mode register |
| alt_mode | input | 2 | Alternate-mode register |
| tlb_hit | input | 1 | The lookup found a matching entry |
| tlb_ppn | input | 32 | Physical page number of the entry |
| tlb_rd_en | input | 4 | Read-enable mask, one bit per mode |
| tlb_wr_en | input | 4 | Write-enable mask, one bit per mode |
| tlb_fault_rd | input | 1 | Fault-on-read bit of the entry |
| tlb_fault_wr | input | 1 | Fault-on-write bit of the entry |
| xlat_pa | output | 44 | Physical address (0 on fault) |
| xlat_uncached | output | 1 | Access is uncacheable |
| xlat_fault | output | 4 | Fault code |

## Verification
The hardest outcomes to reach are MCHK and the uncacheable split. Random 64-bit addresses almost always fail R4, and a random PPN rarely lands near the top of the 44-bit space. The stimulus therefore draws addresses from shaped classes: zero-extended low addresses, the superpage window with bit 40 both set and clear, physical addresses whose upper bits are usually clear, and raw addresses whose bits 43:32 are pinned to all ones or close to it. The PPN is masked to small values most of the time and left wide the rest of the time. Directed cases pin each boundary: the priority of alignment over a physical request, and register space set against ordinary uncacheable space.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        MODE_KERNEL = 2'd0,
        MODE_EXEC   = 2'd1,
        MODE_SUPER  = 2'd2,
        MODE_USER   = 2'd3
    } mode_e;

    typedef enum logic [3:0] {
        FLT_NONE     = 4'd0,
        FLT_ALIGN    = 4'd1,
        FLT_BAD_VA   = 4'd2,
        FLT_ACV      = 4'd3,
        FLT_MISS     = 4'd4,
        FLT_MISS_PTE = 4'd5,
        FLT_FOR      = 4'd6,
        FLT_FOW      = 4'd7,
        FLT_MCHK     = 4'd8
    } fault_e;

    // Tag that VA bits [impl-1 : impl-7] carry inside the superpage window
    localparam logic [6:0] SP_TAG = 7'h7e;

endpackage

// File: rtl/xlat_mode_sel.sv
module xlat_mode_sel
    import xlat_pkg::*;
(
    input  logic  pc_lsb,
    input  logic  alt_req,
    input  mode_e cur_mode,
    input  mode_e alt_mode,
    output mode_e eff_mode
);

    always_comb begin
        if (pc_lsb) begin
            eff_mode = alt_req ? alt_mode : MODE_KERNEL;
        end else begin
            eff_mode = cur_mode;
        end
    end

endmodule

// File: rtl/xlat_va_check.sv
module xlat_va_check
    import xlat_pkg::*;
#(
    parameter int VA_W    = 64,
    parameter int VA_IMPL = 48,
    parameter int PA_W    = 44
) (
    input  logic [VA_W-1:0] va,
    input  logic [1:0]      size_log2,
    output logic            misaligned,
    output logic            bad_va,
    output logic            superpage,
    output logic [PA_W-1:0] sp_pa
);

    localparam int SX_BIT  = PA_W - 4;
    localparam int TAG_LO  = VA_IMPL - 7;
    localparam int HI_BITS = VA_W - VA_IMPL + 1;

    logic [HI_BITS-1:0] hi_bits;
    logic [2:0]         low_mask;

    assign hi_bits = va[VA_W-1:VA_IMPL-1];

    always_comb begin
        unique case (size_log2)
            2'd0:    low_mask = 3'b000;
            2'd1:    low_mask = 3'b001;
            2'd2:    low_mask = 3'b011;
            default: low_mask = 3'b111;
        endcase
        misaligned = |(va[2:0] & low_mask);
        bad_va     = !((&hi_bits) || !(|hi_bits));
        superpage  = !bad_va && (va[VA_IMPL-1:TAG_LO] == SP_TAG);
        sp_pa      = va[PA_W-1:0];
        if (va[SX_BIT]) begin
            sp_pa[PA_W-1:SX_BIT] = '1;
        end else begin
            sp_pa[PA_W-1:SX_BIT] = '0;
        end
    end

endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
    import xlat_pkg::*;
(
    input  logic       is_write,
    input  mode_e      eff_mode,
    input  logic [3:0] rd_en,
    input  logic [3:0] wr_en,
    input  logic       fault_rd,
    input  logic       fault_wr,
    output logic       acv,
    output logic       fault_on
);

    logic mode_ok;

    always_comb begin
        mode_ok  = is_write ? wr_en[eff_mode] : rd_en[eff_mode];
        acv      = !mode_ok;
        fault_on = mode_ok && (is_write ? fault_wr : fault_rd);
    end

endmodule

// File: rtl/xlat_pa_final.sv
module xlat_pa_final #(
    parameter int VA_W = 64,
    parameter int PA_W = 44
) (
    input  logic [VA_W-1:0] raw_pa,
    output logic            mchk,
    output logic            uncached,
    output logic [PA_W-1:0] pa
);

    localparam int REG_LO = PA_W - 12;
    localparam int CLR_HI = PA_W - 2;
    localparam int CLR_LO = PA_W - 9;

    logic reg_space;

    always_comb begin
        mchk      = |raw_pa[VA_W-1:PA_W];
        reg_space = &raw_pa[PA_W-1:REG_LO];
        uncached  = raw_pa[PA_W-1] && !reg_space;
        pa        = raw_pa[PA_W-1:0];
        if (uncached) begin
            pa[CLR_HI:CLR_LO] = '0;
        end
    end

endmodule

// File: rtl/xlat_data_unit.sv
module xlat_data_unit
    import xlat_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int VA_IMPL    = 48,
    parameter int PA_W       = 44,
    parameter int PAGE_SHIFT = 13,
    parameter int PPN_W      = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [VA_W-1:0] req_va,
    input  logic [1:0]      req_size_log2,
    input  logic            req_write,
    input  logic            req_phys,
    input  logic            req_alt,
    input  logic            req_pte,
    input  logic            pc_lsb,
    input  logic [1:0]      cur_mode,
    input  logic [1:0]      alt_mode,
    input  logic            tlb_hit,
    input  logic [PPN_W-1:0] tlb_ppn,
    input  logic [3:0]      tlb_rd_en,
    input  logic [3:0]      tlb_wr_en,
    input  logic            tlb_fault_rd,
    input  logic            tlb_fault_wr,
    output logic [PA_W-1:0] xlat_pa,
    output logic            xlat_uncached,
    output logic [3:0]      xlat_fault
);

    localparam int PPN_PAD = VA_W - PPN_W;
    localparam int OFS_PAD = VA_W - PAGE_SHIFT;
    localparam int SP_PAD  = VA_W - PA_W;

    typedef struct packed {
        logic [PA_W-1:0] pa;
        logic            uncached;
        fault_e          fault;
    } xlat_res_t;

    xlat_res_t res_d, res_q;

    mode_e           eff_mode;
    logic            misaligned, bad_va, superpage;
    logic [PA_W-1:0] sp_pa;
    logic            perm_acv, perm_fo;
    logic [VA_W-1:0] raw_pa, hit_pa;
    logic            formed;
    logic            fin_mchk, fin_unc;
    logic [PA_W-1:0] fin_pa;

    xlat_mode_sel u_mode (
        .pc_lsb   (pc_lsb),
        .alt_req  (req_alt),
        .cur_mode (mode_e'(cur_mode)),
        .alt_mode (mode_e'(alt_mode)),
        .eff_mode (eff_mode)
    );

    xlat_va_check #(
        .VA_W    (VA_W),
        .VA_IMPL (VA_IMPL),
        .PA_W    (PA_W)
    ) u_va (
        .va         (req_va),
        .size_log2  (req_size_log2),
        .misaligned (misaligned),
        .bad_va     (bad_va),
        .superpage  (superpage),
        .sp_pa      (sp_pa)
    );

    xlat_perm u_perm (
        .is_write (req_write),
        .eff_mode (eff_mode),
        .rd_en    (tlb_rd_en),
        .wr_en    (tlb_wr_en),
        .fault_rd (tlb_fault_rd),
        .fault_wr (tlb_fault_wr),
        .acv      (perm_acv),
        .fault_on (perm_fo)
    );

    assign hit_pa = ({{PPN_PAD{1'b0}}, tlb_ppn} << PAGE_SHIFT)
                  + {{OFS_PAD{1'b0}}, req_va[PAGE_SHIFT-1:0]};

    // Priority chain: pick the raw address or the first failing check
    always_comb begin
        raw_pa = '0;
        formed = 1'b0;
        res_d  = '0;
        res_d.fault = FLT_NONE;
        if (misaligned) begin
            res_d.fault = FLT_ALIGN;
        end else if (req_phys) begin
            raw_pa = req_va;
            formed = 1'b1;
        end else if (bad_va) begin
            res_d.fault = FLT_BAD_VA;
        end else if (superpage) begin
            if (eff_mode != MODE_KERNEL) begin
                res_d.fault = FLT_ACV;
            end else begin
                raw_pa = {{SP_PAD{1'b0}}, sp_pa};
                formed = 1'b1;
            end
        end else if (!tlb_hit) begin
            res_d.fault = req_pte ? FLT_MISS_PTE : FLT_MISS;
        end else if (perm_acv) begin
            res_d.fault = FLT_ACV;
        end else if (perm_fo) begin
            res_d.fault = req_write ? FLT_FOW : FLT_FOR;
        end else begin
            raw_pa = hit_pa;
            formed = 1'b1;
        end

        if (formed) begin
            if (fin_mchk) begin
                res_d.fault = FLT_MCHK;
            end else begin
                res_d.pa       = fin_pa;
                res_d.uncached = fin_unc;
            end
        end
    end

    xlat_pa_final #(
        .VA_W (VA_W),
        .PA_W (PA_W)
    ) u_final (
        .raw_pa   (raw_pa),
        .mchk     (fin_mchk),
        .uncached (fin_unc),
        .pa       (fin_pa)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign xlat_pa       = res_q.pa;
    assign xlat_uncached = res_q.uncached;
    assign xlat_fault    = res_q.fault;

endmodule

module xlat_data_chk #(
    parameter int VA_W = 64,
    parameter int PA_W = 44
) (
    input logic            clk,
    input logic            rst_n,
    input logic [VA_W-1:0] req_va,
    input logic [1:0]      req_size_log2,
    input logic            req_phys,
    input logic            req_pte,
    input logic            tlb_hit,
    input logic [PA_W-1:0] xlat_pa,
    input logic            xlat_uncached,
    input logic [3:0]      xlat_fault
);

    logic       past_ok;
    logic [2:0] lowm;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign lowm = req_va[2:0] & ~(3'b111 << req_size_log2);

    // R1
    align_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(lowm != 3'b000) |-> xlat_fault == 4'd1);

    // R13
    fault_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_fault != 4'd0 |-> xlat_pa == '0 && !xlat_uncached);

    // R12
    uncached_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_uncached |-> xlat_pa[PA_W-1] && xlat_pa[PA_W-2:PA_W-9] == '0);

    // R3
    phys_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(lowm == 3'b000 && req_phys && req_va[VA_W-1:PA_W-1] == '0)
        |-> xlat_fault == 4'd0 && xlat_pa == $past(req_va[PA_W-1:0]));

    // R7
    miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(lowm == 3'b000 && !req_phys && !tlb_hit
                         && req_va[VA_W-1:PA_W+3] == '0)
        |-> xlat_fault == ($past(req_pte) ? 4'd5 : 4'd4));

    // R11
    mchk_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && xlat_fault == 4'd8 |-> $past(req_phys) || $past(tlb_hit));

endmodule

bind xlat_data_unit xlat_data_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_xlat_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_va        (req_va),
    .req_size_log2 (req_size_log2),
    .req_phys      (req_phys),
    .req_pte       (req_pte),
    .tlb_hit       (tlb_hit),
    .xlat_pa       (xlat_pa),
    .xlat_uncached (xlat_uncached),
    .xlat_fault    (xlat_fault)
);

// File: tb/xlat_data_unit_test.sv
module xlat_data_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] req_va = '0;
    logic [1:0]  req_size_log2 = '0;
    logic        req_write = 1'b0, req_phys = 1'b0, req_alt = 1'b0, req_pte = 1'b0;
    logic        pc_lsb = 1'b0;
    logic [1:0]  cur_mode = '0, alt_mode = '0;
    logic        tlb_hit = 1'b0;
    logic [31:0] tlb_ppn = '0;
    logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
    logic        tlb_fault_rd = 1'b0, tlb_fault_wr = 1'b0;
    logic [43:0] xlat_pa;
    logic        xlat_uncached;
    logic [3:0]  xlat_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    xlat_data_unit uut (
        .clk(clk), .rst_n(rst_n), .req_va(req_va), .req_size_log2(req_size_log2),
        .req_write(req_write), .req_phys(req_phys), .req_alt(req_alt), .req_pte(req_pte),
        .pc_lsb(pc_lsb), .cur_mode(cur_mode), .alt_mode(alt_mode), .tlb_hit(tlb_hit),
        .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en),
        .tlb_fault_rd(tlb_fault_rd), .tlb_fault_wr(tlb_fault_wr),
        .xlat_pa(xlat_pa), .xlat_uncached(xlat_uncached), .xlat_fault(xlat_fault)
    );

    // Expected result {fault, uncached, pa} from the requirements
    function automatic logic [48:0] ref_result();
        logic [1:0]  m;
        logic        mis, ok;
        logic [63:0] raw;
        logic        have;
        logic [3:0]  f;
        logic [43:0] pa;
        logic        unc;
        m = pc_lsb ? (req_alt ? alt_mode : 2'd0) : cur_mode;            // R2
        case (req_size_log2)
            2'd0: mis = 1'b0;
            2'd1: mis = req_va[0];
            2'd2: mis = req_va[1:0] != 2'b00;
            default: mis = req_va[2:0] != 3'b000;
        endcase
        f = 4'd0; have = 1'b0; raw = '0; pa = '0; unc = 1'b0;
        if (mis) f = 4'd1;                                                // R1
        else if (req_phys) begin raw = req_va; have = 1'b1; end           // R3
        else if (!(req_va[63:47] == '0 || req_va[63:47] == '1)) f = 4'd2; // R4
        else if (req_va[47:41] == 7'h7e) begin                            // R5
            if (m != 2'd0) f = 4'd3;
            else begin                                                    // R6
                raw = {20'd0, req_va[40] ? 4'hf : 4'h0, req_va[39:0]};
                have = 1'b1;
            end
        end
        else if (!tlb_hit) f = req_pte ? 4'd5 : 4'd4;                     // R7
        else begin
            ok = req_write ? tlb_wr_en[m] : tlb_rd_en[m];
            if (!ok) f = 4'd3;                                            // R9
            else if (req_write && tlb_fault_wr) f = 4'd7;                 // R10
            else if (!req_write && tlb_fault_rd) f = 4'd6;
            else begin
                raw = {32'd0, tlb_ppn} * 64'd8192 + {51'd0, req_va[12:0]}; // R8
                have = 1'b1;
            end
        end
        if (have) begin
            if (raw[63:44] != '0) f = 4'd8;                               // R11
            else begin
                pa = raw[43:0];
                if (raw[43] && raw[43:32] != 12'hfff) begin               // R12
                    unc = 1'b1;
                    pa[42:35] = 8'd0;
                end
            end
        end
        return {f, unc, pa};
    endfunction

    task automatic step(input string tag);
        logic [48:0] exp;
        exp = ref_result();
        @(posedge clk);
        @(negedge clk);
        checks++;
        if ({xlat_fault, xlat_uncached, xlat_pa} !== exp) begin
            errors++;
            $display("FAIL %s: got fault=%0d unc=%0b pa=%h expected fault=%0d unc=%0b pa=%h",
                     tag, xlat_fault, xlat_uncached, xlat_pa, exp[48:45], exp[44], exp[43:0]);
        end
    endtask

    task automatic clear_req();
        req_va = '0; req_size_log2 = 2'd3; req_write = 0; req_phys = 0; req_alt = 0;
        req_pte = 0; pc_lsb = 0; cur_mode = 0; alt_mode = 0; tlb_hit = 0; tlb_ppn = 0;
        tlb_rd_en = 4'hf; tlb_wr_en = 4'hf; tlb_fault_rd = 0; tlb_fault_wr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        checks++;   // R13 reset state
        if (xlat_fault !== 4'd0 || xlat_pa !== '0 || xlat_uncached !== 1'b0) begin
            errors++;
            $display("FAIL R13 reset: got fault=%0d pa=%h expected 0 0", xlat_fault, xlat_pa);
        end
        rst_n = 1'b1;

        // R1: misaligned physical request still faults ALIGN
        clear_req(); req_phys = 1; req_va = 64'h1004; req_size_log2 = 2'd3; step("R1 align over phys");
        clear_req(); req_va = 64'hffff_0000_0000_0001; req_size_log2 = 2'd1; step("R1 align over bad VA");
        // R3
        clear_req(); req_phys = 1; req_va = 64'h0000_0123_4567_8000; tlb_hit = 0; step("R3 phys pass");
        // R4
        clear_req(); req_va = 64'h0001_0000_0000_0000; step("R4 bad VA");
        // R5, R2
        clear_req(); req_va = 64'hffff_fc00_0000_1000; cur_mode = 2'd3; step("R5 superpage user");
        clear_req(); req_va = 64'hffff_fc00_0000_1000; cur_mode = 2'd3; pc_lsb = 1; step("R2 pc lsb kernel");
        clear_req(); req_va = 64'hffff_fc00_0000_1000; pc_lsb = 1; req_alt = 1; alt_mode = 2'd2; step("R2 alt mode");
        // R6
        clear_req(); req_va = 64'hffff_fd23_4567_8000; step("R6 sext set");
        clear_req(); req_va = 64'hffff_fcf3_4567_8000; step("R6 sext clear");
        // R7
        clear_req(); req_va = 64'h0000_0000_0040_0000; req_pte = 1; step("R7 pte miss");
        clear_req(); req_va = 64'h0000_0000_0040_0000; step("R7 miss");
        // R8
        clear_req(); tlb_hit = 1; tlb_ppn = 32'h1234; req_va = 64'h0000_0000_0000_1ab8; step("R8 hit pa");
        // R9
        clear_req(); tlb_hit = 1; req_write = 1; cur_mode = 2'd3; tlb_wr_en = 4'h7; step("R9 write acv");
        clear_req(); tlb_hit = 1; cur_mode = 2'd1; tlb_rd_en = 4'hd; tlb_fault_rd = 1; step("R9 read acv first");
        // R10
        clear_req(); tlb_hit = 1; req_write = 1; tlb_fault_wr = 1; tlb_fault_rd = 0; step("R10 FOW");
        clear_req(); tlb_hit = 1; tlb_fault_rd = 1; tlb_fault_wr = 0; step("R10 FOR");
        // R11
        clear_req(); tlb_hit = 1; tlb_ppn = 32'h8000_0000; step("R11 mchk hit");
        clear_req(); req_phys = 1; req_va = 64'h0000_1000_0000_0000; step("R11 mchk phys");
        // R12
        clear_req(); req_phys = 1; req_va = 64'h0000_0812_3456_7890; step("R12 uncached");
        clear_req(); req_phys = 1; req_va = 64'h0000_0fff_0000_0040; step("R12 register space");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int cls;
            cls = $urandom % 6;
            req_va = {$urandom, $urandom};
            case (cls)
                1: req_va[63:47] = '0;
                2: req_va[63:41] = {16'hffff, 7'h7e};
                3: begin req_phys = 1; if ($urandom % 4 != 0) req_va[63:44] = '0; end
                4: begin req_va[63:44] = '0; req_va[43:32] = ($urandom % 2) ? 12'hfff : 12'hffe; end
                default: ;
            endcase
            if (cls != 3) req_phys = ($urandom % 8 == 0);
            req_size_log2 = 2'($urandom);
            if ($urandom % 4 != 0) req_va[2:0] = 3'b000;
            req_write = 1'($urandom); req_alt = 1'($urandom); req_pte = 1'($urandom);
            pc_lsb = 1'($urandom); cur_mode = 2'($urandom); alt_mode = 2'($urandom);
            tlb_hit = ($urandom % 4 != 0);
            tlb_ppn = $urandom;
            if ($urandom % 4 != 0) tlb_ppn[31] = 1'b0;
            tlb_rd_en = 4'($urandom) | (($urandom % 2) ? 4'hf : 4'h0);
            tlb_wr_en = 4'($urandom) | (($urandom % 2) ? 4'hf : 4'h0);
            tlb_fault_rd = ($urandom % 4 == 0); tlb_fault_wr = ($urandom % 4 == 0);
            step("R1-R13 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule